// File: doc/BRIEF.md
# FP64 Round-to-Integral Unit

This block takes one IEEE-754 double-precision operand and returns the integral value nearest to it under a selected rounding mode. The result is still encoded as a double. It also produces an invalid flag and an inexact flag. The rounding mode comes from one of two places, picked by a bit of an 8-bit control byte: either the two low bits of that byte, or a 2-bit global rounding-control input. The choice applies to the one operation only. A further control bit suppresses the inexact flag.

The result is 128 bits wide. Only the low 64 bits are computed. The upper 64 bits are taken from one of two 128-bit sources: the prior destination value when `merge_sel` is 0, or a second source when it is 1. Signalling NaNs come out quieted. When a flush flag is set, denormal inputs are replaced by a signed zero before rounding. Each operation is accepted with `in_valid`, and its result appears one clock later with `out_valid`.

Top module: `fp64_rint`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and `result` holds that operation's value. After reset, `out_valid`, `result` and both flags are 0.
- R2: The mode source depends on `ctrl[2]`. When `ctrl[2]`=1 the mode is `glob_rc`; when `ctrl[2]`=0 it is `ctrl[1:0]`. The mode codes are 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. `ctrl[7:4]` has no effect, and a mode used in one operation does not carry into the next.
- R3: A finite input with 1 <= |x| < 2^52 is rounded to an integer under the selected mode. A tie in mode 00 goes to the even neighbour, so 2.5 gives 2.0 and -2.5 gives -2.0. A carry into the next binade is handled, so 2^52-0.5 gives 2^52.
- R4: A nonzero input with |x| < 1 gives either a zero or 1.0, carrying the input's sign in both cases. For example, -0.3 rounded up gives -0.0.
- R5: Infinities, zeros and inputs with unbiased exponent 52 or more come out unchanged and raise no flag.
- R6: A signalling NaN input (bit 51 = 0) gives the same value with bit 51 set and the payload and sign kept, and it raises `flag_invalid`. A quiet NaN passes through unchanged and raises no flag. `flag_invalid` is raised for no other input.
- R7: `flag_inexact` is 1 exactly when nonzero fraction bits were discarded and `ctrl[3]`=0. When `ctrl[3]`=1 it is never 1.
- R8: When `flush_den`=1, a denormal input gives a zero of the same sign with no flag. When `flush_den`=0, a denormal is rounded like any other value below 1.
- R9: `result[127:64]` equals `dst_prev[127:64]` when `merge_sel`=0 and `src_hi[127:64]` when `merge_sel`=1.
- R10: Both flags are 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| src | input | 64 | Double-precision operand |
| ctrl | input | 8 | Control byte: [1:0] mode, [2] mode source, [3] inexact suppress |
| glob_rc | input | 2 | Global rounding-control mode |
| flush_den | input | 1 | Treat denormal inputs as signed zero |
| merge_sel | input | 1 | Upper-lane source: 0 prior destination, 1 second source |
| dst_prev | input | 128 | Prior destination value |
| src_hi | input | 128 | Second 128-bit source |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Merged 128-bit result |
| flag_invalid | output | 1 | Invalid exception flag |
| flag_inexact | output | 1 | Inexact (precision) exception flag |

## Verification
Every result, both flags and the merged upper lane are due on the first rising edge after the edge that captured `in_valid`. No output has a deeper path than that.

The bench drives each operation on a falling edge and compares all outputs on the next falling edge, which is half a cycle after the single output register loads. It then drops `in_valid` and, one falling edge later, confirms that `out_valid` and both flags have returned to 0.

// File: rtl/fp64_rint.sv
module fp64_rint #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+FRAC_W:0]  src,
  input  logic [7:0]             ctrl,
  input  logic [1:0]             glob_rc,
  input  logic                   flush_den,
  input  logic                   merge_sel,
  input  logic [2*(EXP_W+FRAC_W+1)-1:0] dst_prev,
  input  logic [2*(EXP_W+FRAC_W+1)-1:0] src_hi,
  output logic                   out_valid,
  output logic [2*(EXP_W+FRAC_W+1)-1:0] result,
  output logic                   flag_invalid,
  output logic                   flag_inexact
);
  localparam int DW   = EXP_W + FRAC_W + 1;
  localparam int LW   = 2 * DW;
  localparam int MW   = FRAC_W + 1;
  localparam int BIAS = 2**(EXP_W-1) - 1;
  localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] HALF_E = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] INT_E  = EXP_W'(BIAS + FRAC_W);
  localparam logic [MW-1:0]    UNIT   = MW'(1);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  assign sgn = src[DW-1];
  assign ex  = src[DW-2:FRAC_W];
  assign fr  = src[FRAC_W-1:0];

  logic exp_max, exp_zero, fr_nz, is_nan, is_snan, is_den;
  assign exp_max  = &ex;
  assign exp_zero = ~|ex;
  assign fr_nz    = |fr;
  assign is_nan   = exp_max & fr_nz;
  assign is_snan  = is_nan & ~fr[FRAC_W-1];
  assign is_den   = exp_zero & fr_nz;

  logic [1:0] mode;
  assign mode = ctrl[2] ? glob_rc : ctrl[1:0];

  // fractional-bit count for BIAS <= ex < INT_E, range 1..FRAC_W
  logic [EXP_W-1:0] fsh, fsh_m1, ex_inc;
  assign fsh    = INT_E - ex;
  assign fsh_m1 = fsh - EXP_W'(1);
  assign ex_inc = ex + EXP_W'(1);

  logic [MW-1:0] mant, keep, intp, rem, half, step;
  logic          lsb, up;
  logic [MW:0]   sum;
  assign mant = {1'b1, fr};
  assign keep = {MW{1'b1}} << fsh;
  assign intp = mant & keep;
  assign rem  = mant & ~keep;
  assign half = UNIT << fsh_m1;
  assign step = UNIT << fsh;
  assign lsb  = |(mant & step);

  always_comb begin
    case (mode)
      2'b00:   up = (rem > half) || ((rem == half) && lsb);
      2'b01:   up = sgn && (rem != '0);
      2'b10:   up = !sgn && (rem != '0);
      default: up = 1'b0;
    endcase
  end

  assign sum = {1'b0, intp} + (up ? {1'b0, step} : '0);

  logic tiny_one;
  always_comb begin
    case (mode)
      2'b00:   tiny_one = (ex == HALF_E) && fr_nz;
      2'b01:   tiny_one = sgn;
      2'b10:   tiny_one = !sgn;
      default: tiny_one = 1'b0;
    endcase
  end

  logic [DW-1:0] lo;
  logic          inv_c, inx_c;
  always_comb begin
    lo    = src;
    inv_c = 1'b0;
    inx_c = 1'b0;
    if (is_nan) begin
      lo[FRAC_W-1] = 1'b1;
      inv_c        = is_snan;
    end else if (flush_den && is_den) begin
      lo = {sgn, {(DW-1){1'b0}}};
    end else if (exp_max || (ex >= INT_E) || (exp_zero && !fr_nz)) begin
      lo = src;
    end else if (ex < BIAS_E) begin
      lo    = {sgn, tiny_one ? BIAS_E : '0, {FRAC_W{1'b0}}};
      inx_c = 1'b1;
    end else begin
      lo    = sum[MW] ? {sgn, ex_inc, {FRAC_W{1'b0}}} : {sgn, ex, sum[FRAC_W-1:0]};
      inx_c = (rem != '0);
    end
  end

  logic [DW-1:0] hi;
  assign hi = merge_sel ? src_hi[LW-1:DW] : dst_prev[LW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= {hi, lo};
        flag_invalid <= inv_c;
        flag_inexact <= inx_c & ~ctrl[3];
      end else begin
        flag_invalid <= 1'b0;
        flag_inexact <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp64_rint_chk.sv
module fp64_rint_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [EXP_W+FRAC_W:0]  src,
  input logic [7:0]             ctrl,
  input logic                   merge_sel,
  input logic [2*(EXP_W+FRAC_W+1)-1:0] dst_prev,
  input logic [2*(EXP_W+FRAC_W+1)-1:0] src_hi,
  input logic                   out_valid,
  input logic [2*(EXP_W+FRAC_W+1)-1:0] result,
  input logic                   flag_invalid,
  input logic                   flag_inexact
);
  localparam int DW = EXP_W + FRAC_W + 1;
  localparam int LW = 2 * DW;

  logic src_snan, src_inf;
  assign src_snan = (&src[DW-2:FRAC_W]) && (|src[FRAC_W-1:0]) && !src[FRAC_W-1];
  assign src_inf  = (&src[DW-2:FRAC_W]) && !(|src[FRAC_W-1:0]);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R10
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!flag_invalid && !flag_inexact));

  // R7
  inexact_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[3]) |=> !flag_inexact);

  // R6
  invalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flag_invalid == $past(src_snan)));

  // R6
  quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (&result[DW-2:FRAC_W-1]));

  // R9
  merge_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_sel) |=> (result[LW-1:DW] == $past(src_hi[LW-1:DW])));

  // R9
  keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !merge_sel) |=> (result[LW-1:DW] == $past(dst_prev[LW-1:DW])));

  // R5
  inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_inf) |=> ((result[DW-1:0] == $past(src)) && !flag_inexact && !flag_invalid));
endmodule

bind fp64_rint fp64_rint_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .ctrl(ctrl),
  .merge_sel(merge_sel), .dst_prev(dst_prev), .src_hi(src_hi),
  .out_valid(out_valid), .result(result),
  .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
);

// File: tb/fp64_rint_tb.sv
`timescale 1ns/1ps
module fp64_rint_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [63:0]  src = '0;
  logic [7:0]   ctrl = '0;
  logic [1:0]   glob_rc = '0;
  logic         flush_den = 1'b0;
  logic         merge_sel = 1'b0;
  logic [127:0] dst_prev = '0;
  logic [127:0] src_hi = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         flag_invalid, flag_inexact;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #2 clk = ~clk;

  fp64_rint u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .ctrl(ctrl),
    .glob_rc(glob_rc), .flush_den(flush_den), .merge_sel(merge_sel),
    .dst_prev(dst_prev), .src_hi(src_hi), .out_valid(out_valid),
    .result(result), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  task automatic lcg(output logic [63:0] v);
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    v = seed ^ (seed >> 29);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ref_round(input logic [63:0] x, input logic [1:0] m, input bit fz,
                           output logic [63:0] y, output bit inx, output bit inv);
    real r, fl, q, d;
    logic [10:0] e;
    e = x[62:52];
    y = x; inx = 1'b0; inv = 1'b0;
    if (e == 11'h7ff) begin
      if (x[51:0] != 0) begin
        y   = x | (64'd1 << 51);
        inv = !x[51];
      end
    end else if (fz && e == 0) begin
      y = {x[63], 63'd0};
    end else begin
      r = $bitstoreal(x);
      if (!(r >= 4503599627370496.0 || r <= -4503599627370496.0)) begin
        fl = $floor(r);
        case (m)
          2'd0: begin
            d = r - fl;
            if (d > 0.5) q = fl + 1.0;
            else if (d < 0.5) q = fl;
            else q = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
          end
          2'd1: q = fl;
          2'd2: q = $ceil(r);
          default: q = (r < 0.0) ? $ceil(r) : fl;
        endcase
        inx = (q != r);
        y = (q == 0.0) ? {x[63], 63'd0} : $realtobits(q);
      end
    end
  endtask

  task automatic run(input logic [63:0] x, input logic [7:0] c, input logic [1:0] g,
                     input bit fz, input bit ms, input string req);
    logic [63:0]  ey, r1, r2;
    logic [127:0] dp, sh;
    logic [63:0]  ehi;
    bit           einx, einv;
    lcg(r1); lcg(r2);
    dp = {r1, r2};
    lcg(r1); lcg(r2);
    sh = {r2, r1};
    ref_round(x, c[2] ? g : c[1:0], fz, ey, einx, einv);
    ehi = ms ? sh[127:64] : dp[127:64];
    @(negedge clk);
    src = x; ctrl = c; glob_rc = g; flush_den = fz; merge_sel = ms;
    dst_prev = dp; src_hi = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R1
    chk(out_valid == 1'b1, "R1", "out_valid", {127'd0, out_valid}, 128'd1);
    chk(result[63:0] == ey, req, "result", {64'd0, result[63:0]}, {64'd0, ey});
    // R7
    chk(flag_inexact == (einx && !c[3]), "R7", "inexact",
        {127'd0, flag_inexact}, {127'd0, einx && !c[3]});
    // R6
    chk(flag_invalid == einv, "R6", "invalid", {127'd0, flag_invalid}, {127'd0, einv});
    // R9
    chk(result[127:64] == ehi, "R9", "upper", {64'd0, result[127:64]}, {64'd0, ehi});
    @(negedge clk);
    // R10
    chk(!out_valid && !flag_invalid && !flag_inexact, "R10", "idle",
        {125'd0, out_valid, flag_invalid, flag_inexact}, 128'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  real specials [0:21] = '{
    2.5, -2.5, 1.5, -1.5, 3.5, 0.5, -0.5, 0.3, -0.3, 0.7, -0.99, 1.0,
    2251799813685248.5, -2251799813685248.5, 2251799813685249.5,
    4503599627370495.5, -4503599627370495.5, 4503599627370496.0,
    4503599627370497.0, -4503599627370497.0, 9007199254740994.0, 1.0e300
  };

  logic [63:0] oddbits [0:11] = '{
    64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h7FF8_0000_0000_1234, 64'hFFFC_0000_00AB_CDEF,
    64'h7FF0_0000_0000_00AB, 64'hFFF4_5555_0000_0001,
    64'h0000_0000_0000_0001, 64'h800F_FFFF_FFFF_FFFF,
    64'h0008_0000_0000_0000, 64'h8000_0000_0000_0100
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && result == '0 && !flag_invalid && !flag_inexact, "R1", "reset",
        {result[127:3], out_valid, flag_invalid, flag_inexact}, 128'd0);
    rst_n = 1'b1;

    // R3 quarter-step grid, mode from the immediate field
    for (int k = -24; k <= 24; k++)
      for (int m = 0; m < 4; m++)
        run($realtobits(k * 0.25), {4'h0, 2'b00, 2'(m)}, ~2'(m), 1'b0, k[0], "R3");

    // R2 mode from global input, immediate field and upper bits hold other values
    for (int k = -24; k <= 24; k++)
      for (int m = 0; m < 4; m++)
        run($realtobits(k * 0.25), {4'hA, 2'b01, ~2'(m)}, 2'(m), 1'b0, ~k[0], "R2");

    // R3 R4 R5 ties, small magnitudes, exponent 51..53 boundaries
    foreach (specials[i])
      for (int m = 0; m < 4; m++) begin
        run($realtobits(specials[i]), {4'h5, 2'b00, 2'(m)}, 2'd0, 1'b0, 1'b0,
            (specials[i] < 1.0 && specials[i] > -1.0) ? "R4" : "R3");
        run($realtobits(specials[i]), {4'h0, 2'b11, 2'(m ^ 1)}, 2'(m), 1'b1, 1'b1, "R5");
      end

    // R5 R6 R8 infinities, zeros, NaNs, denormals with flush on and off
    foreach (oddbits[i])
      for (int m = 0; m < 4; m++)
        for (int f = 0; f < 2; f++)
          run(oddbits[i], {4'h0, f[0], 1'b0, 2'(m)}, 2'd0, f[0], f[0],
              (oddbits[i][62:52] == 0 && oddbits[i][51:0] != 0) ? "R8" :
              (oddbits[i][62:52] == 11'h7ff && oddbits[i][51:0] != 0) ? "R6" : "R5");

    // R3 R7 pseudo-random operands around the integral range
    for (int n = 0; n < 400; n++) begin
      lcg(rv);
      rv[62:52] = 11'(1020 + (rv[62:52] % 58));
      for (int m = 0; m < 4; m++)
        run(rv, {rv[7:4], n[0], 1'b0, 2'(m)}, 2'd3, rv[9], rv[8], "R3");
    end

    summary();
    $finish;
  end
endmodule